// File: doc/BRIEF.md
# Status Register and Write-Permission Guard

This block keeps the status byte of a serial memory device and rules on every write the device is asked to perform. A serial front-end (not part of this block) decodes each command and hands it over as a one-cycle code on `cmd_op`, together with the target address of an array write or the new status byte of a status write. The block tracks each chip-select frame and remembers the first command seen in it. At the end of the frame, when `cs_n` returns high, it either grants the write or drops it silently. A grant is a single-cycle permit pulse. The write-enable latch, the two region-lock bits and the pin-guard enable bit are plain registers that are cleared by reset.

A frame moves through these states. `F_IDLE` means chip select is high. `F_OPEN` means chip select is low and no command has arrived yet. The first command then picks one of the following:
- `F_WEL_SET`: arm setting of the write-enable latch.
- `F_WEL_CLR`: arm clearing of the write-enable latch.
- `F_SR_ARMED`: a status write that has so far been allowed.
- `F_ARR_ARMED`: an allowed array write.
- `F_DISCARD`: a command that is refused, unknown, or arrived while the device was busy.

There are two transitions out of these states. Any state returns to `F_IDLE` when `cs_n` is high, and that is the cycle in which the frame commits. `F_SR_ARMED` falls to `F_DISCARD` whenever the hardware guard becomes active during the frame.

Top module: `sreg_guard`

## Requirements
- R1: After reset, `status_q` reads 0x00 while `wr_busy` is low. The write-enable latch is 0, as are the lock and guard bits.
- R2: The latch-set command (`cmd_op`=1) changes status bit 1 only in the cycle that follows the `cs_n`-high cycle ending its frame. Both permit pulses occur only while `cs_n` is high.
- R3: The latch-clear command (`cmd_op`=2) clears status bit 1 when its frame ends. Bit 1 keeps its value during the frame.
- R4: Status bit 1 clears on its own in the cycle after `wr_busy` falls.
- R5: A granted status write (`cmd_op`=3, byte on `cmd_sr_data`) copies data bits 7, 3 and 2 into status bits 7, 3 and 2. `sr_wr_ok` pulses in the `cs_n`-high cycle that ends the frame. Status bits 6..4 always read 0. Bits 1 and 0 are never taken from the data, and bits 7..2 change only through a granted status write.
- R6: While `wp_n` is low and status bit 7 is 1, a status write is refused. Array writes to unlocked addresses are still granted if bit 1 is 1.
- R7: If `wp_n` goes low while status bit 7 is 1 during an armed status-write frame, that write is cancelled, even if `wp_n` returns high before the frame ends.
- R8: An array write (`cmd_op`=4, address on `cmd_addr`) is refused when its address is locked. Status bits 3:2 select the locked range: 00 locks nothing, 01 locks the top quarter (0x6000-0x7FFF), 10 locks the top half (0x4000-0x7FFF), and 11 locks all addresses.
- R9: An array write is granted only if status bit 1 was 1 when the command arrived.
- R10: Every command that arrives while `wr_busy` is high is ignored, and its frame grants nothing.
- R11: Only the first command of a frame counts. Later commands in the same frame, and codes 5..7, have no effect.
- R12: Status bit 0 equals `wr_busy`.
- R13: When status bit 7 is 0, or `wp_n` is high, a status write needs only bit 1 set, whatever the level of `wp_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select (synchronized). High marks the end of a frame |
| cmd_op | input | 3 | Decoded command, valid for one cycle: 0 none, 1 latch set, 2 latch clear, 3 status write, 4 array write, 5-7 other |
| cmd_addr | input | ADDR_W (15) | Target address, valid with `cmd_op`=4 |
| cmd_sr_data | input | 8 | Offered status byte, valid with `cmd_op`=3 |
| wp_n | input | 1 | Write-protect pin, active low |
| wr_busy | input | 1 | Write cycle in progress, from the write-cycle controller |
| status_q | output | 8 | Status byte: bit 7 guard enable, bits 3:2 region lock, bit 1 write-enable latch, bit 0 busy |
| arr_wr_ok | output | 1 | One-cycle permit for the frame's array write |
| sr_wr_ok | output | 1 | One-cycle permit for the frame's status write |

## Verification
The hardest case to reach from the ports is cancelling an armed status write. It needs the write-enable latch set and bit 7 already stored as 1, which takes an earlier granted status write, a busy pulse, and a second latch-set frame. Then, with the pin high at the moment of arming, `wp_n` must pulse low for a single cycle between the command and the end of the frame. The directed sequence builds that state step by step and then checks two things: that no permit appears even though the pin is high again when the frame closes, and that the status byte has not moved.

// File: rtl/sreg_guard_pkg.sv
package sreg_guard_pkg;

    localparam int SR_W      = 8;
    localparam int SR_GUARD  = 7;
    localparam int SR_LOCK_H = 3;
    localparam int SR_LOCK_L = 2;
    localparam int SR_WEL    = 1;
    localparam int SR_BUSY   = 0;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_WEL_SET   = 3'd1,
        OP_WEL_CLR   = 3'd2,
        OP_SR_WRITE  = 3'd3,
        OP_ARR_WRITE = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        F_IDLE,
        F_OPEN,
        F_WEL_SET,
        F_WEL_CLR,
        F_SR_ARMED,
        F_ARR_ARMED,
        F_DISCARD
    } frame_e;

    typedef struct packed {
        logic sr_load;
        logic wel_set;
        logic wel_clr;
        logic sr_commit;
        logic arr_commit;
    } commit_t;

endpackage

// File: rtl/sreg_region_check.sv
module sreg_region_check #(
    parameter int ADDR_W = 15
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        lock_sel,
    output logic              locked
);
    localparam int MSB = ADDR_W - 1;

    always_comb begin
        unique case (lock_sel)
            2'b00:   locked = 1'b0;
            2'b01:   locked = addr[MSB] & addr[MSB-1];
            2'b10:   locked = addr[MSB];
            default: locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/sreg_frame_fsm.sv
module sreg_frame_fsm
    import sreg_guard_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cs_n,
    input  logic [2:0] cmd_op,
    input  logic    busy,
    input  logic    wel,
    input  logic    hw_lock,
    input  logic    arr_locked,
    output commit_t commit
);
    frame_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= F_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (state == F_IDLE) begin
            if (!cs_n) state_nx = F_OPEN;
        end else if (cs_n) begin
            state_nx = F_IDLE;
        end else begin
            unique case (state)
                F_OPEN: begin
                    if (cmd_op != OP_NONE) begin
                        if (busy) state_nx = F_DISCARD;
                        else begin
                            unique case (cmd_op)
                                OP_WEL_SET:   state_nx = F_WEL_SET;
                                OP_WEL_CLR:   state_nx = F_WEL_CLR;
                                OP_SR_WRITE:  state_nx = (wel && !hw_lock)
                                                         ? F_SR_ARMED : F_DISCARD;
                                OP_ARR_WRITE: state_nx = (wel && !arr_locked)
                                                         ? F_ARR_ARMED : F_DISCARD;
                                default:      state_nx = F_DISCARD;
                            endcase
                        end
                    end
                end
                F_SR_ARMED: if (hw_lock) state_nx = F_DISCARD;
                default:    state_nx = state;
            endcase
        end
    end

    always_comb begin
        commit.sr_load    = (state == F_OPEN) && !cs_n && !busy &&
                            (cmd_op == OP_SR_WRITE);
        commit.wel_set    = cs_n && (state == F_WEL_SET);
        commit.wel_clr    = cs_n && (state == F_WEL_CLR);
        commit.sr_commit  = cs_n && (state == F_SR_ARMED) && !hw_lock;
        commit.arr_commit = cs_n && (state == F_ARR_ARMED);
    end
endmodule

// File: rtl/sreg_store.sv
module sreg_store
    import sreg_guard_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  commit_t         commit,
    input  logic [SR_W-1:0] sr_data,
    input  logic            busy,
    output logic            wel,
    output logic [1:0]      lock_sel,
    output logic            guard_en
);
    logic [SR_W-1:0] staged;
    logic            busy_q;
    logic            cycle_done;

    assign cycle_done = busy_q && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged   <= '0;
            busy_q   <= 1'b0;
            wel      <= 1'b0;
            lock_sel <= 2'b00;
            guard_en <= 1'b0;
        end else begin
            busy_q <= busy;
            if (commit.sr_load) staged <= sr_data;
            if (commit.wel_set)                      wel <= 1'b1;
            else if (commit.wel_clr || cycle_done)   wel <= 1'b0;
            if (commit.sr_commit) begin
                lock_sel <= staged[SR_LOCK_H:SR_LOCK_L];
                guard_en <= staged[SR_GUARD];
            end
        end
    end
endmodule

// File: rtl/sreg_guard.sv
module sreg_guard
    import sreg_guard_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_sr_data,
    input  logic              wp_n,
    input  logic              wr_busy,
    output logic [7:0]        status_q,
    output logic              arr_wr_ok,
    output logic              sr_wr_ok
);
    commit_t    commit;
    logic       wel;
    logic [1:0] lock_sel;
    logic       guard_en;
    logic       hw_lock;
    logic       arr_locked;

    assign hw_lock = guard_en && !wp_n;

    sreg_region_check #(.ADDR_W(ADDR_W)) i_region (
        .addr     (cmd_addr),
        .lock_sel (lock_sel),
        .locked   (arr_locked)
    );

    sreg_frame_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .cmd_op     (cmd_op),
        .busy       (wr_busy),
        .wel        (wel),
        .hw_lock    (hw_lock),
        .arr_locked (arr_locked),
        .commit     (commit)
    );

    sreg_store i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .sr_data  (cmd_sr_data),
        .busy     (wr_busy),
        .wel      (wel),
        .lock_sel (lock_sel),
        .guard_en (guard_en)
    );

    always_comb begin
        status_q            = '0;
        status_q[SR_GUARD]  = guard_en;
        status_q[SR_LOCK_H:SR_LOCK_L] = lock_sel;
        status_q[SR_WEL]    = wel;
        status_q[SR_BUSY]   = wr_busy;
    end

    assign arr_wr_ok = commit.arr_commit;
    assign sr_wr_ok  = commit.sr_commit;
endmodule

// File: rtl/sreg_guard_chk.sv
module sreg_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       wp_n,
    input logic       wr_busy,
    input logic [7:0] status_q,
    input logic       arr_wr_ok,
    input logic       sr_wr_ok
);
    assert_single_permit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_wr_ok && sr_wr_ok));

    assert_arr_needs_wel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_ok |-> status_q[1]);

    assert_arr_full_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_ok |-> (status_q[3:2] != 2'b11));

    assert_sr_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_ok |-> (status_q[1] && !(status_q[7] && !wp_n)));

    assert_permit_frame_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_ok || sr_wr_ok) |-> cs_n);

    assert_spare_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[6:4] == 3'b000);

    assert_sr_change_granted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_q[7:2]) |-> $past(sr_wr_ok));

    assert_wel_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wr_busy) && !cs_n) |=> !status_q[1]);
endmodule

bind sreg_guard sreg_guard_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .wp_n      (wp_n),
    .wr_busy   (wr_busy),
    .status_q  (status_q),
    .arr_wr_ok (arr_wr_ok),
    .sr_wr_ok  (sr_wr_ok)
);

// File: tb/test_sreg_guard.sv
module test_sreg_guard;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] C_NONE = 3'd0, C_SET = 3'd1, C_CLR = 3'd2,
                           C_SR = 3'd3, C_ARR = 3'd4, C_ODD = 3'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic [2:0]  cmd_op = 3'd0;
    logic [14:0] cmd_addr = '0;
    logic [7:0]  cmd_sr_data = '0;
    logic        wp_n = 1'b1;
    logic        wr_busy = 1'b0;
    logic [7:0]  status_q;
    logic        arr_wr_ok, sr_wr_ok;

    int checks = 0;
    int errors = 0;
    logic got_arr, got_sr;
    logic [7:0] mid_sr;

    always #(CLK_PERIOD/2) clk = ~clk;

    sreg_guard i_sreg_guard (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_sr_data(cmd_sr_data), .wp_n(wp_n),
        .wr_busy(wr_busy), .status_q(status_q),
        .arr_wr_ok(arr_wr_ok), .sr_wr_ok(sr_wr_ok)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // One frame: first command, optional second command, optional WP glitch.
    task automatic run_frame(input logic [2:0] op1, input logic [2:0] op2,
                             input logic [14:0] addr, input logic [7:0] data,
                             input logic glitch);
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk) begin cmd_op = op1; cmd_addr = addr; cmd_sr_data = data; end
        @(negedge clk) cmd_op = op2;
        @(negedge clk) begin cmd_op = C_NONE; if (glitch) wp_n = 1'b0; end
        @(negedge clk) if (glitch) wp_n = 1'b1;
        #1 mid_sr = status_q;
        @(negedge clk) cs_n = 1'b1;
        #1 begin got_arr = arr_wr_ok; got_sr = sr_wr_ok; end
        @(negedge clk);
        #1;
    endtask

    task automatic busy_pulse(input logic [7:0] exp_during, input logic [7:0] exp_after);
        @(negedge clk) wr_busy = 1'b1;
        #1 check("R12 busy bit", status_q, exp_during);
        repeat (3) @(negedge clk);
        wr_busy = 1'b0;
        @(negedge clk);
        #1 check("R4 latch drop after busy", status_q, exp_after);
    endtask

    task automatic t_reset;
        check("R1 reset status", status_q, 8'h00);
    endtask

    task automatic t_wel_basics;
        run_frame(C_ARR, C_NONE, 15'h0000, 8'h00, 1'b0);
        check("R9 array write without latch", {7'd0, got_arr}, 8'h00);
        run_frame(C_SET, C_NONE, 15'h0000, 8'h00, 1'b0);
        check("R2 latch unchanged mid-frame", mid_sr, 8'h00);
        check("R2 latch set after frame", status_q, 8'h02);
        run_frame(C_ARR, C_NONE, 15'h1234, 8'h00, 1'b0);
        check("R8 no lock grants array write", {7'd0, got_arr}, 8'h01);
    endtask

    task automatic t_busy_ignore;
        @(negedge clk) wr_busy = 1'b1;
        #1 check("R12 busy bit high", status_q, 8'h03);
        run_frame(C_ARR, C_NONE, 15'h0010, 8'h00, 1'b0);
        check("R10 array write while busy", {7'd0, got_arr}, 8'h00);
        @(negedge clk) wr_busy = 1'b0;
        @(negedge clk);
        #1 check("R4 latch cleared by end of cycle", status_q, 8'h00);
    endtask

    task automatic t_sr_write;
        run_frame(C_SET, C_NONE, 15'h0, 8'h00, 1'b0);
        run_frame(C_SR, C_NONE, 15'h0, 8'hFF, 1'b0);
        check("R5 status write granted", {7'd0, got_sr}, 8'h01);
        check("R5 only bits 7,3,2 taken", status_q, 8'h8E);
        busy_pulse(8'h8F, 8'h8C);
    endtask

    task automatic t_hw_lock;
        run_frame(C_SET, C_NONE, 15'h0, 8'h00, 1'b0);
        wp_n = 1'b0;
        run_frame(C_SR, C_NONE, 15'h0, 8'h00, 1'b0);
        check("R6 status write refused under guard", {7'd0, got_sr}, 8'h00);
        check("R6 status unchanged", status_q, 8'h8E);
        run_frame(C_ARR, C_NONE, 15'h0000, 8'h00, 1'b0);
        check("R8 full lock refuses address 0", {7'd0, got_arr}, 8'h00);
        wp_n = 1'b1;
    endtask

    task automatic t_quarter;
        run_frame(C_SR, C_NONE, 15'h0, 8'h84, 1'b0);
        check("R5 status write with pin high", {7'd0, got_sr}, 8'h01);
        busy_pulse(8'h87, 8'h84);
        run_frame(C_SET, C_NONE, 15'h0, 8'h00, 1'b0);
        wp_n = 1'b0;
        run_frame(C_ARR, C_NONE, 15'h5FFF, 8'h00, 1'b0);
        check("R6 unlocked region writable under guard", {7'd0, got_arr}, 8'h01);
        run_frame(C_ARR, C_NONE, 15'h6000, 8'h00, 1'b0);
        check("R8 quarter lock low edge", {7'd0, got_arr}, 8'h00);
        run_frame(C_ARR, C_NONE, 15'h7FFF, 8'h00, 1'b0);
        check("R8 quarter lock top", {7'd0, got_arr}, 8'h00);
        wp_n = 1'b1;
    endtask

    task automatic t_glitch;
        run_frame(C_SR, C_NONE, 15'h0, 8'h00, 1'b1);
        check("R7 pin glitch cancels status write", {7'd0, got_sr}, 8'h00);
        check("R7 status kept", status_q, 8'h86);
    endtask

    task automatic t_guard_off;
        run_frame(C_SR, C_NONE, 15'h0, 8'h08, 1'b0);
        check("R13 status write clears guard", status_q, 8'h0A);
        busy_pulse(8'h0B, 8'h08);
        run_frame(C_SET, C_NONE, 15'h0, 8'h00, 1'b0);
        wp_n = 1'b0;
        run_frame(C_SR, C_NONE, 15'h0, 8'h08, 1'b0);
        check("R13 pin low but guard off grants", {7'd0, got_sr}, 8'h01);
        run_frame(C_ARR, C_NONE, 15'h3FFF, 8'h00, 1'b0);
        check("R8 half lock below", {7'd0, got_arr}, 8'h01);
        run_frame(C_ARR, C_NONE, 15'h4000, 8'h00, 1'b0);
        check("R8 half lock boundary", {7'd0, got_arr}, 8'h00);
        wp_n = 1'b1;
    endtask

    task automatic t_first_only;
        run_frame(C_CLR, C_ARR, 15'h0000, 8'h00, 1'b0);
        check("R3 latch held mid-frame", mid_sr, 8'h0A);
        check("R11 second command ignored", {7'd0, got_arr}, 8'h00);
        check("R3 latch cleared after frame", status_q, 8'h08);
        run_frame(C_SET, C_ARR, 15'h0000, 8'h00, 1'b0);
        check("R11 write after set in same frame", {7'd0, got_arr}, 8'h00);
        check("R2 latch set by frame", status_q, 8'h0A);
        run_frame(C_ODD, C_SR, 15'h0000, 8'hFF, 1'b0);
        check("R11 unknown code blocks frame", {7'd0, got_sr}, 8'h00);
        check("R11 status unchanged", status_q, 8'h0A);
    endtask

    task automatic t_busy_sr;
        @(negedge clk) wr_busy = 1'b1;
        run_frame(C_SR, C_NONE, 15'h0, 8'h80, 1'b0);
        check("R10 status write while busy", {7'd0, got_sr}, 8'h00);
        check("R10 status during busy", status_q, 8'h0B);
        @(negedge clk) wr_busy = 1'b0;
        @(negedge clk);
        #1 check("R10 status after busy", status_q, 8'h08);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset();
        t_wel_basics();
        t_busy_ignore();
        t_sr_write();
        t_hw_lock();
        t_quarter();
        t_glitch();
        t_guard_off();
        t_first_only();
        t_busy_sr();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule